// File: doc/BRIEF.md
# Dual-compare 16-bit timer unit

This block is the timer peripheral of a small 8-bit controller. A free-running 16-bit counter advances once per clock while `count_en` is high. The counter can be captured on an external event and compared against two independent compare registers. The CPU reaches the counter, the capture register, both compare registers and two control/status registers through a byte-wide register bus. On this bus a read takes effect at the clock edge that ends the access cycle, and read data is valid during that cycle.

Four events raise flags: a capture, a match on channel 1, a match on channel 2 and a counter wrap. Each flag has its own interrupt enable, and the gated results leave the block as a request vector. A flag does not clear when it is written. Software clears it in two steps: it reads a status register while the flag is set, then it reads the data register that belongs to the flag. Each compare channel can also take over one port pin. The block then forces that pin's direction to output and drives the programmed level onto it when the channel matches.

Top module: `dct_timer`

## Requirements
- R1: After reset, CTRL1 (address 0) reads 0x00, CTRL2 (address 7) reads 0x10, both compare registers read 0xFFFF, and `irq_req`, `pin_dir_force` and `pin_level` are all zero.
- R2: Each clock edge with `count_en` high adds one to the counter (high byte at address 1, low byte at address 2). A step from 0xFFFF to 0x0000 sets the overflow flag, which is CTRL1 bit 5.
- R3: A write to address 1 latches the data byte and presets the counter to 0xFFF8. A write to address 2 loads the counter with {latched byte, data byte}. A counter write takes priority over counting in that cycle.
- R4: A one-cycle pulse on `cap_edge` copies the current counter into the capture register (high byte at address 5, low byte at address 6) and sets the capture flag, which is CTRL1 bit 7.
- R5: A compare match happens when a count step brings the counter to the value of a compare register. Channel 1 is at addresses 3 and 4 and sets CTRL1 bit 6. Channel 2 is at addresses 8 and 9 and sets CTRL2 bit 5. The flag sets at the same edge as the step. Each byte of a compare register is written on its own.
- R6: On a match with its output enabled, a channel copies its level bit onto its pin. Channel 1 takes CTRL1 bit 0 onto `pin_level[1]`. Channel 2 takes CTRL2 bit 2 onto `pin_level[5]`. The pin level holds until the next enabled match.
- R7: CTRL2 bit 0 drives `pin_dir_force[1]` and CTRL2 bit 1 drives `pin_dir_force[5]`. The forcing does not wait for a match.
- R8: CTRL2 reads {capture flag, compare-1 flag, compare-2 flag, 1, bits 3..0}. A write to CTRL2 changes only bits 3..0, and the compare-2 flag keeps its value.
- R9: A read of CTRL1 or CTRL2 arms each flag that is set and that the register shows. After arming, one read clears the flag: address 5 for capture, address 3 or 4 for compare 1, address 8 or 9 for compare 2, and address 1 for overflow. A data read with no arming leaves the flag set.
- R10: If a flag's event occurs again after the flag was armed, the arming is cancelled. Another status read is then needed before a data read can clear the flag.
- R11: `irq_req` bit 0 is capture AND CTRL1 bit 4. Bit 1 is compare 1 AND CTRL1 bit 3. Bit 2 is compare 2 AND CTRL2 bit 3. Bit 3 is overflow AND CTRL1 bit 2.
- R12: CTRL1 reads {capture flag, compare-1 flag, overflow flag, bit 4, bit 3, bit 2, 0, bit 0}. A write to CTRL1 changes only bits 4, 3, 2 and 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| count_en | input | 1 | Counter advance enable, one step per clock |
| cap_edge | input | 1 | Capture event pulse |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| irq_req | output | 4 | Enabled flags: overflow, compare 2, compare 1, capture |
| pin_dir_force | output | 8 | Port direction bits forced to output |
| pin_level | output | 8 | Levels driven on the forced port pins |

## Verification
The hardest condition to reach is a flag event that lands between the arming status read and the clearing data read. The bench creates it with the capture path, because `cap_edge` can be pulsed at any cycle with the counter stopped. It reads CTRL1, pulses a second capture and then reads the capture register, and it expects the request to stay raised. The bench checks flag state through `irq_req`, so observing a flag never arms it. It checks the clear-without-arming case for the capture, compare 1 and overflow flags.

// File: rtl/dct_pkg.sv
package dct_pkg;
    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL1   = 4'h0,
        A_CNT_HI  = 4'h1,
        A_CNT_LO  = 4'h2,
        A_CMP1_HI = 4'h3,
        A_CMP1_LO = 4'h4,
        A_CAP_HI  = 4'h5,
        A_CAP_LO  = 4'h6,
        A_CTRL2   = 4'h7,
        A_CMP2_HI = 4'h8,
        A_CMP2_LO = 4'h9
    } reg_addr_e;

    // control, flag and arm state held by the top
    typedef struct packed {
        logic en_cap;
        logic en_c1;
        logic en_ovf;
        logic lvl1;
        logic oe1;
        logic oe2;
        logic lvl2;
        logic en_c2;
        logic f_cap;
        logic f_c1;
        logic f_c2;
        logic f_ovf;
        logic a_cap;
        logic a_c1;
        logic a_c2;
        logic a_ovf;
    } ctl_state_t;
endpackage

// File: rtl/dct_counter.sv
module dct_counter #(
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  inc,
    input  logic                  wr_hi,
    input  logic                  wr_lo,
    input  logic [DATA_W-1:0]     wdata,
    input  logic                  cap_edge,
    output logic [2*DATA_W-1:0]   cnt,
    output logic [2*DATA_W-1:0]   cnt_next,
    output logic [2*DATA_W-1:0]   cap,
    output logic                  step,
    output logic                  wrap
);
    localparam int CNT_W = 2 * DATA_W;
    localparam logic [CNT_W-1:0] ALL1   = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] PRESET = ALL1 - CNT_W'(7);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] hi_latch;
        logic [CNT_W-1:0]  cap;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_hi) begin
            st_d.hi_latch = wdata;
            st_d.cnt      = PRESET;
        end else if (wr_lo) begin
            st_d.cnt = {st_q.hi_latch, wdata};
        end else if (inc) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
        if (cap_edge) begin
            st_d.cap = st_q.cnt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt      = st_q.cnt;
    assign cap      = st_q.cap;
    assign cnt_next = st_d.cnt;
    assign step     = inc & ~wr_hi & ~wr_lo;
    assign wrap     = step & (st_q.cnt == ALL1);

    // R3
    preset_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> cnt == PRESET);

    // R2
    count_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cnt == ALL1) |=> cnt == '0);

    // R4
    capture_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_edge |=> cap == $past(cnt));
endmodule

// File: rtl/dct_compare.sv
module dct_compare #(
    parameter int DATA_W = 8,
    parameter logic [2*DATA_W-1:0] RESET_VAL = '1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_hi,
    input  logic                  wr_lo,
    input  logic [DATA_W-1:0]     wdata,
    input  logic                  step,
    input  logic [2*DATA_W-1:0]   cnt_next,
    input  logic                  out_en,
    input  logic                  level,
    output logic [2*DATA_W-1:0]   cmp_val,
    output logic                  match,
    output logic                  pin
);
    localparam int CNT_W = 2 * DATA_W;

    typedef struct packed {
        logic [CNT_W-1:0] cmp;
        logic             pin;
    } cmp_state_t;

    cmp_state_t st_d, st_q;

    assign match = step & (cnt_next == st_q.cmp);

    always_comb begin
        st_d = st_q;
        if (wr_hi) begin
            st_d.cmp[CNT_W-1:DATA_W] = wdata;
        end
        if (wr_lo) begin
            st_d.cmp[DATA_W-1:0] = wdata;
        end
        if (match && out_en) begin
            st_d.pin = level;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cmp <= RESET_VAL;
            st_q.pin <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmp_val = st_q.cmp;
    assign pin     = st_q.pin;

    // R6
    pin_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (match && out_en) |=> pin == $past(level));

    // R6
    pin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(match && out_en) |=> $stable(pin));
endmodule

// File: rtl/dct_timer.sv
module dct_timer
    import dct_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int PORT_W  = 8,
    parameter int PIN_CH1 = 1,
    parameter int PIN_CH2 = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                count_en,
    input  logic                cap_edge,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic [3:0]          irq_req,
    output logic [PORT_W-1:0]   pin_dir_force,
    output logic [PORT_W-1:0]   pin_level
);
    localparam int CNT_W = 2 * DATA_W;
    localparam int NCH   = 2;

    logic rd, wr;
    logic rd_ctrl1, rd_ctrl2, rd_cap_hi, rd_cnt_hi, rd_cmp1, rd_cmp2;
    logic wr_ctrl1, wr_ctrl2, wr_cnt_hi, wr_cnt_lo;

    assign rd = bus_sel & ~bus_wr;
    assign wr = bus_sel & bus_wr;

    assign rd_ctrl1  = rd & (bus_addr == A_CTRL1);
    assign rd_ctrl2  = rd & (bus_addr == A_CTRL2);
    assign rd_cap_hi = rd & (bus_addr == A_CAP_HI);
    assign rd_cnt_hi = rd & (bus_addr == A_CNT_HI);
    assign rd_cmp1   = rd & ((bus_addr == A_CMP1_HI) | (bus_addr == A_CMP1_LO));
    assign rd_cmp2   = rd & ((bus_addr == A_CMP2_HI) | (bus_addr == A_CMP2_LO));
    assign wr_ctrl1  = wr & (bus_addr == A_CTRL1);
    assign wr_ctrl2  = wr & (bus_addr == A_CTRL2);
    assign wr_cnt_hi = wr & (bus_addr == A_CNT_HI);
    assign wr_cnt_lo = wr & (bus_addr == A_CNT_LO);

    ctl_state_t st_d, st_q;

    logic [CNT_W-1:0] cnt, cnt_next, cap;
    logic             step, wrap;

    dct_counter #(.DATA_W(DATA_W)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (count_en),
        .wr_hi    (wr_cnt_hi),
        .wr_lo    (wr_cnt_lo),
        .wdata    (bus_wdata),
        .cap_edge (cap_edge),
        .cnt      (cnt),
        .cnt_next (cnt_next),
        .cap      (cap),
        .step     (step),
        .wrap     (wrap)
    );

    logic [NCH-1:0]   c_oe, c_lvl, c_match, c_pin, c_wr_hi, c_wr_lo;
    logic [CNT_W-1:0] c_val [NCH];

    assign c_oe  = {st_q.oe2, st_q.oe1};
    assign c_lvl = {st_q.lvl2, st_q.lvl1};

    for (genvar g = 0; g < NCH; g++) begin : g_cmp
        localparam logic [ADDR_W-1:0] HI_A = (g == 0) ? A_CMP1_HI : A_CMP2_HI;
        localparam logic [ADDR_W-1:0] LO_A = (g == 0) ? A_CMP1_LO : A_CMP2_LO;
        assign c_wr_hi[g] = wr & (bus_addr == HI_A);
        assign c_wr_lo[g] = wr & (bus_addr == LO_A);
        dct_compare #(.DATA_W(DATA_W), .RESET_VAL({CNT_W{1'b1}})) u_cmp (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_hi    (c_wr_hi[g]),
            .wr_lo    (c_wr_lo[g]),
            .wdata    (bus_wdata),
            .step     (step),
            .cnt_next (cnt_next),
            .out_en   (c_oe[g]),
            .level    (c_lvl[g]),
            .cmp_val  (c_val[g]),
            .match    (c_match[g]),
            .pin      (c_pin[g])
        );
    end

    always_comb begin
        st_d = st_q;
        if (wr_ctrl1) begin
            {st_d.en_cap, st_d.en_c1, st_d.en_ovf} = bus_wdata[4:2];
            st_d.lvl1 = bus_wdata[0];
        end
        if (wr_ctrl2) begin
            {st_d.en_c2, st_d.lvl2, st_d.oe2, st_d.oe1} = bus_wdata[3:0];
        end
        // status reads arm the flags they show
        if (rd_ctrl1) begin
            if (st_q.f_cap) st_d.a_cap = 1'b1;
            if (st_q.f_c1)  st_d.a_c1  = 1'b1;
            if (st_q.f_ovf) st_d.a_ovf = 1'b1;
        end
        if (rd_ctrl2) begin
            if (st_q.f_cap) st_d.a_cap = 1'b1;
            if (st_q.f_c1)  st_d.a_c1  = 1'b1;
            if (st_q.f_c2)  st_d.a_c2  = 1'b1;
        end
        // data reads clear armed flags
        if (rd_cap_hi && st_q.a_cap) begin
            st_d.f_cap = 1'b0;
            st_d.a_cap = 1'b0;
        end
        if (rd_cmp1 && st_q.a_c1) begin
            st_d.f_c1 = 1'b0;
            st_d.a_c1 = 1'b0;
        end
        if (rd_cmp2 && st_q.a_c2) begin
            st_d.f_c2 = 1'b0;
            st_d.a_c2 = 1'b0;
        end
        if (rd_cnt_hi && st_q.a_ovf) begin
            st_d.f_ovf = 1'b0;
            st_d.a_ovf = 1'b0;
        end
        // new events win and cancel any arming
        if (cap_edge) begin
            st_d.f_cap = 1'b1;
            st_d.a_cap = 1'b0;
        end
        if (c_match[0]) begin
            st_d.f_c1 = 1'b1;
            st_d.a_c1 = 1'b0;
        end
        if (c_match[1]) begin
            st_d.f_c2 = 1'b1;
            st_d.a_c2 = 1'b0;
        end
        if (wrap) begin
            st_d.f_ovf = 1'b1;
            st_d.a_ovf = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    logic [7:0] ctrl1_b, ctrl2_b;
    assign ctrl1_b = {st_q.f_cap, st_q.f_c1, st_q.f_ovf, st_q.en_cap,
                      st_q.en_c1, st_q.en_ovf, 1'b0, st_q.lvl1};
    assign ctrl2_b = {st_q.f_cap, st_q.f_c1, st_q.f_c2, 1'b1,
                      st_q.en_c2, st_q.lvl2, st_q.oe2, st_q.oe1};

    always_comb begin
        unique case (bus_addr)
            A_CTRL1:   bus_rdata = DATA_W'(ctrl1_b);
            A_CTRL2:   bus_rdata = DATA_W'(ctrl2_b);
            A_CNT_HI:  bus_rdata = cnt[CNT_W-1:DATA_W];
            A_CNT_LO:  bus_rdata = cnt[DATA_W-1:0];
            A_CMP1_HI: bus_rdata = c_val[0][CNT_W-1:DATA_W];
            A_CMP1_LO: bus_rdata = c_val[0][DATA_W-1:0];
            A_CMP2_HI: bus_rdata = c_val[1][CNT_W-1:DATA_W];
            A_CMP2_LO: bus_rdata = c_val[1][DATA_W-1:0];
            A_CAP_HI:  bus_rdata = cap[CNT_W-1:DATA_W];
            A_CAP_LO:  bus_rdata = cap[DATA_W-1:0];
            default:   bus_rdata = '0;
        endcase
    end

    assign irq_req = {st_q.f_ovf & st_q.en_ovf, st_q.f_c2 & st_q.en_c2,
                      st_q.f_c1 & st_q.en_c1, st_q.f_cap & st_q.en_cap};

    always_comb begin
        pin_dir_force          = '0;
        pin_dir_force[PIN_CH1] = st_q.oe1;
        pin_dir_force[PIN_CH2] = st_q.oe2;
        pin_level              = '0;
        pin_level[PIN_CH1]     = c_pin[0];
        pin_level[PIN_CH2]     = c_pin[1];
    end

    // R9
    cmp1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cmp1 && !st_q.a_c1 && st_q.f_c1) |=> st_q.f_c1);

    // R9
    cap_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cap_hi && st_q.a_cap && !cap_edge) |=> !st_q.f_cap);

    // R8
    ctrl2_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl2 && !c_match[1] && !rd_cmp2) |=> st_q.f_c2 == $past(st_q.f_c2));

    // R4
    cap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_edge |=> st_q.f_cap);

    // R10
    rearm_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_match[0] |=> !st_q.a_c1);
endmodule

// File: tb/tb_dct_timer.sv
module tb_dct_timer;
    import dct_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       count_en = 1'b0;
    logic       cap_edge = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [3:0] irq_req;
    logic [7:0] pin_dir_force;
    logic [7:0] pin_level;

    int checks = 0;
    int fails  = 0;
    logic done = 1'b0;

    always #10 clk = ~clk;

    dct_timer dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .count_en      (count_en),
        .cap_edge      (cap_edge),
        .bus_sel       (bus_sel),
        .bus_wr        (bus_wr),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .irq_req       (irq_req),
        .pin_dir_force (pin_dir_force),
        .pin_level     (pin_level)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic run(input int n);
        @(negedge clk);
        count_en = 1'b1;
        repeat (n) @(negedge clk);
        count_en = 1'b0;
    endtask

    task automatic pulse_cap();
        @(negedge clk);
        cap_edge = 1'b1;
        @(negedge clk);
        cap_edge = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d, e;
        bus_read(A_CTRL1, d);  check(d == 8'h00, "R1 ctrl1 reset", d, 8'h00);
        bus_read(A_CTRL2, d);  check(d == 8'h10, "R1 ctrl2 reset", d, 8'h10);
        bus_read(A_CMP2_HI, d); bus_read(A_CMP2_LO, e);
        check({d, e} == 16'hFFFF, "R1 cmp2 reset", {d, e}, 16'hFFFF);
        bus_read(A_CMP1_HI, d); bus_read(A_CMP1_LO, e);
        check({d, e} == 16'hFFFF, "R1 cmp1 reset", {d, e}, 16'hFFFF);
        check({irq_req, pin_dir_force, pin_level} == '0, "R1 outputs reset",
              {irq_req, pin_dir_force, pin_level}, 0);
    endtask

    task automatic t_load();
        logic [7:0] d, e;
        bus_write(A_CNT_HI, 8'h12);
        bus_read(A_CNT_HI, d); bus_read(A_CNT_LO, e);
        check({d, e} == 16'hFFF8, "R3 high write presets", {d, e}, 16'hFFF8);
        bus_write(A_CNT_LO, 8'h34);
        bus_read(A_CNT_HI, d); bus_read(A_CNT_LO, e);
        check({d, e} == 16'h1234, "R3 low write loads", {d, e}, 16'h1234);
        run(3);
        bus_read(A_CNT_LO, e);
        check(e == 8'h37, "R2 counts per enabled clock", e, 8'h37);
        bus_write(A_CNT_HI, 8'h12);
        bus_write(A_CNT_LO, 8'h34);
    endtask

    task automatic t_cmp1();
        logic [7:0] d;
        bus_write(A_CMP1_HI, 8'h12);
        bus_write(A_CMP1_LO, 8'h38);
        bus_write(A_CTRL1, 8'h09);
        bus_write(A_CTRL2, 8'h01);
        check(pin_dir_force == 8'h02, "R7 oe1 forces dir", pin_dir_force, 8'h02);
        run(3);
        check(irq_req == 4'b0000, "R5 no early match", irq_req, 0);
        run(1);
        check(irq_req == 4'b0010, "R5 R11 cmp1 match irq", irq_req, 4'b0010);
        check(pin_level == 8'h02, "R6 cmp1 pin level", pin_level, 8'h02);
        bus_read(A_CMP1_HI, d);
        check(irq_req[1] == 1'b1, "R9 unarmed read keeps cmp1", irq_req[1], 1);
        bus_read(A_CTRL2, d);
        check(d == 8'h51, "R8 ctrl2 mirrors cmp1 flag", d, 8'h51);
        bus_read(A_CMP1_LO, d);
        check(irq_req[1] == 1'b0, "R9 armed read clears cmp1", irq_req[1], 0);
    endtask

    task automatic t_ctrl2();
        logic [7:0] d;
        bus_write(A_CTRL2, 8'hFF);
        bus_read(A_CTRL2, d);
        check(d == 8'h1F, "R8 ctrl2 write low nibble only", d, 8'h1F);
        check(pin_dir_force == 8'h22, "R7 both dirs forced", pin_dir_force, 8'h22);
        bus_write(A_CTRL2, 8'h0E);
        check(pin_dir_force == 8'h20, "R7 oe2 only", pin_dir_force, 8'h20);
    endtask

    task automatic t_cmp2();
        logic [7:0] d;
        bus_write(A_CMP2_HI, 8'h12);
        bus_write(A_CMP2_LO, 8'h40);
        run(8);
        check(irq_req == 4'b0100, "R5 R11 cmp2 match irq", irq_req, 4'b0100);
        check(pin_level == 8'h22, "R6 cmp2 pin level", pin_level, 8'h22);
        bus_write(A_CTRL2, 8'h06);
        check(irq_req[2] == 1'b0, "R11 cmp2 enable off", irq_req[2], 0);
        bus_write(A_CTRL2, 8'h0E);
        check(irq_req[2] == 1'b1, "R8 write keeps cmp2 flag", irq_req[2], 1);
        bus_read(A_CTRL2, d);
        check(d == 8'h3E, "R8 ctrl2 shows cmp2 flag", d, 8'h3E);
        bus_read(A_CMP2_HI, d);
        check(irq_req[2] == 1'b0, "R9 armed read clears cmp2", irq_req[2], 0);
    endtask

    task automatic t_capture();
        logic [7:0] d, e;
        bus_write(A_CTRL1, 8'h19);
        pulse_cap();
        check(irq_req[0] == 1'b1, "R4 capture flag irq", irq_req[0], 1);
        bus_read(A_CAP_HI, d); bus_read(A_CAP_LO, e);
        check({d, e} == 16'h1240, "R4 capture value", {d, e}, 16'h1240);
        check(irq_req[0] == 1'b1, "R9 unarmed read keeps capture", irq_req[0], 1);
        bus_read(A_CTRL1, d);
        check(d == 8'h99, "R12 ctrl1 shows capture flag", d, 8'h99);
        pulse_cap();
        bus_read(A_CAP_HI, d);
        check(irq_req[0] == 1'b1, "R10 new event cancels arming", irq_req[0], 1);
        bus_read(A_CTRL1, d);
        bus_read(A_CAP_HI, d);
        check(irq_req[0] == 1'b0, "R9 armed read clears capture", irq_req[0], 0);
        bus_write(A_CTRL1, 8'hFF);
        bus_read(A_CTRL1, d);
        check(d == 8'h1D, "R12 ctrl1 writable bits", d, 8'h1D);
    endtask

    task automatic t_overflow();
        logic [7:0] d;
        bus_write(A_CNT_HI, 8'hFF);
        bus_write(A_CNT_LO, 8'hFE);
        run(1);
        check(irq_req[3] == 1'b0, "R2 no overflow at FFFF", irq_req[3], 0);
        run(1);
        check(irq_req[3] == 1'b1, "R2 R11 overflow on wrap", irq_req[3], 1);
        bus_read(A_CNT_HI, d);
        check(d == 8'h00, "R2 wrapped to zero", d, 0);
        check(irq_req[3] == 1'b1, "R9 unarmed read keeps overflow", irq_req[3], 1);
        bus_read(A_CTRL1, d);
        check(d[5] == 1'b1, "R12 ctrl1 shows overflow", d, 8'h3D);
        bus_read(A_CNT_HI, d);
        check(irq_req[3] == 1'b0, "R9 armed read clears overflow", irq_req[3], 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_load();
        t_cmp1();
        t_ctrl2();
        t_cmp2();
        t_capture();
        t_overflow();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule